// File: doc/BRIEF.md
# Vector Shift-Right-Narrow Lane Unit

This SIMD datapath block takes a 128-bit wide vector operand, treats it as equal lanes of 16, 32 or 64 bits, logically shifts every lane right by an immediate amount and keeps only the low half of each shifted lane. The halved lanes are packed into a 64-bit narrow result. Lane 0 sits in the least significant bits of both the operand and the result, and destination lane i always comes from source lane i.

A single 6-bit immediate field carries both the lane size and the shift amount. The leading one of the immediate selects the lane size, and the remaining value gives the shift as the lane width minus the immediate. An immediate whose top three bits are zero is not a legal encoding. It raises an illegal flag and forces a zero result. The result is registered and appears one cycle after the input strobe. The block has no condition flags and no rounding or saturation. Signed and unsigned lanes are handled in the same way.

Top module: `narrow_shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_illegal` and `out_result` are cleared to zero at that edge.
- R2: `out_valid` equals `in_valid` sampled at the previous clock edge, so there is one cycle of latency.
- R3: An immediate with bits 5:3 = 001 selects 16-bit source lanes. Each is shifted right by 16 minus the immediate (8 down to 1), and the low 8 bits go to 8-bit result lane i, at result bits 8i+7:8i.
- R4: An immediate with bits 5:4 = 01 selects 32-bit source lanes. Each is shifted right by 32 minus the immediate (16 down to 1), and the low 16 bits go to result bits 16i+15:16i.
- R5: An immediate with bit 5 = 1 selects 64-bit source lanes. Each is shifted right by 64 minus the immediate (32 down to 1), and the low 32 bits go to result bits 32i+31:32i.
- R6: The shift is logical. Zeros enter from the top of each lane, no sign bit is copied and no rounding or saturation is applied. An all-ones operand therefore yields all-ones result lanes for every legal shift.
- R7: Source lane i is taken from operand bits starting at i times the source lane width, so lane 0 is the least significant. No bits cross between lanes.
- R8: An accepted immediate with bits 5:3 = 000 sets `out_illegal` and gives `out_result` = 0. Any legal immediate clears `out_illegal`.
- R9: A cycle with `in_valid` low leaves `out_result` and `out_illegal` unchanged.
- R10: For every legal immediate, the decoded shift lies between 1 and half the source lane width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and immediate are valid this cycle |
| in_operand | input | 128 | Wide vector operand, lane 0 in the low bits |
| in_imm | input | 6 | Immediate holding lane size and shift amount |
| out_valid | output | 1 | Result-valid strobe, one cycle after `in_valid` |
| out_result | output | 64 | Packed narrowed lanes |
| out_illegal | output | 1 | Last accepted immediate was an illegal encoding |

## Verification
The bench builds the unit with its default widths: a 128-bit operand, a 64-bit result and a 6-bit immediate. With these widths all three lane sizes can be reached, from eight 16-bit lanes down to two 64-bit lanes, together with the full legal immediate range and the illegal 000xxx group. Directed steps cover the minimum and maximum shift of each lane size with all-ones, alternating and lane-indexed operands. A pseudo-random run then covers mixed immediates and idle cycles. Every cycle is compared against a per-bit behavioural model.

// File: rtl/nsu_pkg.sv
package nsu_pkg;

    localparam int IMM_W    = 6;
    localparam int SHAMT_W  = 7;
    localparam int N_SIZES  = 3;
    localparam int MIN_LANE = 16;

    typedef enum logic [1:0] {
        LANE_16   = 2'd0,
        LANE_32   = 2'd1,
        LANE_64   = 2'd2,
        LANE_NONE = 2'd3
    } lane_sel_e;

    typedef struct packed {
        lane_sel_e            sel;
        logic [SHAMT_W-1:0]   shamt;
        logic                 illegal;
    } imm_dec_t;

    // Leading one of the immediate picks the lane size; shift = width - imm.
    function automatic imm_dec_t decode_imm(input logic [IMM_W-1:0] imm);
        imm_dec_t d;
        logic [SHAMT_W-1:0] ext;
        ext       = {1'b0, imm};
        d.sel     = LANE_NONE;
        d.shamt   = '0;
        d.illegal = 1'b0;
        if (imm[5]) begin
            d.sel   = LANE_64;
            d.shamt = 7'd64 - ext;
        end else if (imm[4]) begin
            d.sel   = LANE_32;
            d.shamt = 7'd32 - ext;
        end else if (imm[3]) begin
            d.sel   = LANE_16;
            d.shamt = 7'd16 - ext;
        end else begin
            d.illegal = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/nsu_decode.sv
module nsu_decode
    import nsu_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    output imm_dec_t         dec
);

    always_comb begin
        dec = decode_imm(imm);
    end

endmodule

// File: rtl/nsu_lane_array.sv
module nsu_lane_array
    import nsu_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64,
    parameter int SRC_W    = 16
) (
    input  logic [WIDE_W-1:0]   operand,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [NARROW_W-1:0] narrowed
);

    localparam int DST_W = SRC_W / 2;
    localparam int LANES = WIDE_W / SRC_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Logical shift within the lane, then keep the low half.
        assign narrowed[i*DST_W +: DST_W] =
            DST_W'(operand[i*SRC_W +: SRC_W] >> shamt);
    end

endmodule

// File: rtl/narrow_shift_unit.sv
module narrow_shift_unit
    import nsu_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NARROW_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WIDE_W-1:0]   in_operand,
    input  logic [IMM_W-1:0]    in_imm,
    output logic                out_valid,
    output logic [NARROW_W-1:0] out_result,
    output logic                out_illegal
);

    imm_dec_t            dec;
    logic [NARROW_W-1:0] cand [N_SIZES];
    logic [NARROW_W-1:0] res_nxt;

    nsu_decode u_decode (
        .imm (in_imm),
        .dec (dec)
    );

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        nsu_lane_array #(
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W),
            .SRC_W    (MIN_LANE << k)
        ) u_lanes (
            .operand  (in_operand),
            .shamt    (dec.shamt),
            .narrowed (cand[k])
        );
    end

    always_comb begin
        case (dec.sel)
            LANE_16: res_nxt = cand[0];
            LANE_32: res_nxt = cand[1];
            LANE_64: res_nxt = cand[2];
            default: res_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= res_nxt;
                out_illegal <= dec.illegal;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_imm[5:3] == 3'b000) |=> out_illegal);
    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_result == '0);
    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
    // R10
    shamt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec.illegal) |->
            (dec.shamt != '0 && dec.shamt <= (7'd8 << dec.sel)));

endmodule

// File: tb/narrow_shift_unit_bench.sv
module narrow_shift_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_operand;
    logic [5:0]   in_imm;
    logic         out_valid;
    logic [63:0]  out_result;
    logic         out_illegal;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic        exp_valid;
    logic [63:0] exp_res;
    logic        exp_ill;

    always #2.5 clk = ~clk;

    narrow_shift_unit u_narrow_shift_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_imm      (in_imm),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    // Per-bit behavioural model: returns {illegal, result}.
    function automatic logic [64:0] ref_model(input logic [127:0] op,
                                              input logic [5:0] imm);
        int es;
        int sh;
        logic [63:0] r;
        r = '0;
        if (imm[5])      es = 64;
        else if (imm[4]) es = 32;
        else if (imm[3]) es = 16;
        else return {1'b1, 64'd0};
        sh = es - int'(imm);
        for (int o = 0; o < 64; o++) begin
            int lane = o / (es / 2);
            int b    = o % (es / 2);
            if (b + sh < es) r[o] = op[lane * es + b + sh];
        end
        return {1'b0, r};
    endfunction

    task automatic check1(input string tag, input logic [63:0] act,
                          input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check1({tag, " valid"},   {63'd0, out_valid},   {63'd0, exp_valid});
        check1({tag, " result"},  out_result,           exp_res);
        check1({tag, " illegal"}, {63'd0, out_illegal}, {63'd0, exp_ill});
    endtask

    // Called at a falling edge: drive, advance one cycle, compare.
    task automatic step(input logic v, input logic [127:0] op,
                        input logic [5:0] imm, input string tag);
        logic [64:0] m;
        in_valid   = v;
        in_operand = op;
        in_imm     = imm;
        exp_valid  = v;
        if (v) begin
            m       = ref_model(op, imm);
            exp_ill = m[64];
            exp_res = m[63:0];
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] ones;
        logic [127:0] alt;
        logic [127:0] idx;
        logic [127:0] sgn;
        logic [31:0]  lfsr;
        ones = '1;
        alt  = {8{16'hA5C3}};
        sgn  = {8{16'h8001}};
        for (int j = 0; j < 16; j++) idx[j*8 +: 8] = 8'(j * 17 + 1);
        rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_imm = '0;
        exp_valid = 0; exp_res = '0; exp_ill = 0;
        repeat (3) @(negedge clk);
        in_valid = 1'b1; in_imm = 6'd40; in_operand = ones;
        @(negedge clk);
        check_all("R1 reset");
        rst = 1'b0;
        // R3 16-bit lanes, max and min shift
        step(1, ones, 6'd8,  "R3 R6 16b sh8 ones");
        step(1, ones, 6'd15, "R3 R6 16b sh1 ones");
        step(1, alt,  6'd8,  "R3 16b sh8 alt");
        step(1, alt,  6'd15, "R3 16b sh1 alt");
        step(1, sgn,  6'd12, "R6 16b no sign fill");
        // R4 32-bit lanes
        step(1, ones, 6'd16, "R4 R6 32b sh16 ones");
        step(1, ones, 6'd31, "R4 32b sh1 ones");
        step(1, alt,  6'd16, "R4 32b sh16 alt");
        step(1, alt,  6'd31, "R4 32b sh1 alt");
        // R5 64-bit lanes
        step(1, ones, 6'd32, "R5 R6 64b sh32 ones");
        step(1, ones, 6'd63, "R5 64b sh1 ones");
        step(1, alt,  6'd32, "R5 64b sh32 alt");
        step(1, alt,  6'd63, "R5 64b sh1 alt");
        // R7 lane order with distinct lane content
        step(1, idx, 6'd9,  "R7 16b order");
        step(1, idx, 6'd20, "R7 32b order");
        step(1, idx, 6'd50, "R7 64b order");
        // R8 illegal immediates
        step(1, ones, 6'd0, "R8 imm0");
        step(0, alt,  6'd9, "R9 hold illegal");
        step(1, ones, 6'd7, "R8 imm7");
        step(1, ones, 6'd8, "R8 legal clears");
        // R9 idle cycles hold result
        step(0, alt,  6'd0,  "R9 idle1");
        step(0, idx,  6'd33, "R2 R9 idle2");
        // R10 mixed pseudo-random run
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 60; n++) begin
            logic [127:0] op;
            for (int w = 0; w < 4; w++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                op[w*32 +: 32] = lfsr;
            end
            step(lfsr[7:5] != 3'd0, op, lfsr[13:8], "R10 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule